// File: doc/BRIEF.md
# Translation Miss Merging Buffer

This block sits between a translation cache and a small pool of page table walkers. Each miss that leaves the cache enters here with its virtual page number, its address-space ID and a requester tag. A miss to a page that already has a pending, non-stale entry with the same address-space ID is attached to that entry by setting its tag bit. Otherwise the miss takes a free entry. Waiting entries are handed to walkers, and at most a fixed number of walks are in flight at once. When a walk result comes back, every requester attached to the entry gets its own answer.

A path register keeps the page number and address-space ID of the last walk that completed without going stale. Each new walk request carries a skip count: the number of leading upper-level table indices it shares with that record. The walker can then start that many levels lower. A page-table update is signalled by an invalidation pulse. It clears the path register and marks every pending entry as stale. A stale entry still answers its requesters, but it does not refresh the path register and it does not accept new misses.

Each entry runs its own four-state machine. FREE goes to WAIT when a miss is allocated to it. WAIT goes to WALK when the entry is issued to a walker. WALK goes to DONE when its walk result arrives. DONE goes back to FREE when its last waiting tag has been answered.

Top module: `miss_merge_buf`

## Requirements
- R1: After reset, `miss_ready` is 1, and `walk_req_valid` and `rsp_valid` are 0.
- R2: A miss whose page number and address-space ID equal those of a WAIT or WALK entry that is not stale is accepted into that entry, and no further walk request is made for it.
- R3: Misses to the same page number under different address-space IDs occupy separate entries, get separate walks, and each response carries its own address-space ID and walk result.
- R4: There are 32 entries. When all 32 are in use and a miss matches none of them, `miss_ready` is 0. A miss that matches a pending entry is still accepted.
- R5: At most 4 walks are in flight. When a walker frees up, the WAIT entry with the lowest index is issued next, and `walk_req_id` carries that index.
- R6: A completed walk produces one response per attached tag, in ascending tag order, on consecutive cycles. Each response carries the entry's page number, its address-space ID and the walked PPN. The entry is free after the last response.
- R7: `walk_req_skip` equals the number of leading level indices (9 bits each, most significant level first, 4 levels) that the requested page shares with the path register, capped at 3. It is 0 when the path register is empty or its address-space ID differs.
- R8: An invalidation pulse empties the path register, so the next walk request has skip 0.
- R9: A walk that was in flight or waiting when an invalidation arrived still answers its requesters but leaves the path register unchanged. A later miss to the same page does not merge into it and starts a new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss is presented |
| miss_ready | output | 1 | The miss can be accepted this cycle |
| miss_vpn | input | 36 | Virtual page number of the miss |
| miss_asid | input | 8 | Address-space ID of the miss |
| miss_tag | input | 3 | Requester tag |
| inval | input | 1 | Page-table update pulse |
| walk_req_valid | output | 1 | A walk is issued this cycle |
| walk_req_id | output | 5 | Entry index of the walk |
| walk_req_vpn | output | 36 | Page to walk |
| walk_req_asid | output | 8 | Address space to walk |
| walk_req_skip | output | 2 | Upper levels that may be skipped |
| walk_rsp_valid | input | 1 | A walk result arrives |
| walk_rsp_id | input | 5 | Entry index of the result |
| walk_rsp_ppn | input | 24 | Physical page number from the walk |
| rsp_valid | output | 1 | A translation answer is presented |
| rsp_tag | output | 3 | Requester tag being answered |
| rsp_vpn | output | 36 | Page number of the answer |
| rsp_asid | output | 8 | Address-space ID of the answer |
| rsp_ppn | output | 24 | Physical page number of the answer |

## Verification
The hardest state to reach is a stale entry that sits alongside a fresh entry for the same page. The walk has to be held open across an invalidation, and then a second miss to that page has to arrive. The bench holds every walk result until it chooses to reply. This lets it issue the first walk, pulse the invalidation, send the repeat miss and observe a second walk request. It then answers the stale walk first and confirms that the next skip count still reflects an empty path register. Full occupancy is reached by filling all 32 entries while only four walks can drain. Skip counts are swept from zero up to a full match against a path model kept in the bench.

// File: rtl/mmb_pkg.sv
`timescale 1ns/1ps
package mmb_pkg;
    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_WAIT = 2'd1,
        ENT_WALK = 2'd2,
        ENT_DONE = 2'd3
    } ent_state_e;
endpackage

// File: rtl/mmb_pick.sv
`timescale 1ns/1ps
module mmb_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/mmb_match.sv
`timescale 1ns/1ps
module mmb_match #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 36,
    parameter int ASID_W  = 8,
    localparam int EID_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             mergeable,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]               look_vpn,
    input  logic [ASID_W-1:0]              look_asid,
    output logic                           hit,
    output logic [EID_W-1:0]               hit_idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = mergeable[g] && (ent_vpn[g] == look_vpn) && (ent_asid[g] == look_asid);
    end

    mmb_pick #(.N(ENTRIES)) u_pick (.req(eq), .any(hit), .idx(hit_idx));
endmodule

// File: rtl/mmb_path.sv
`timescale 1ns/1ps
module mmb_path #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int ASID_W = 8,
    localparam int VPN_W  = LEVELS * IDX_W,
    localparam int SKIP_W = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval,
    input  logic              upd_valid,
    input  logic              upd_stale,
    input  logic [VPN_W-1:0]  upd_vpn,
    input  logic [ASID_W-1:0] upd_asid,
    input  logic [VPN_W-1:0]  look_vpn,
    input  logic [ASID_W-1:0] look_asid,
    output logic [SKIP_W-1:0] look_skip
);
    logic              pv_q;
    logic [VPN_W-1:0]  pvpn_q;
    logic [ASID_W-1:0] pasid_q;
    logic [LEVELS-1:0] lvl_eq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_q    <= 1'b0;
            pvpn_q  <= '0;
            pasid_q <= '0;
        end else if (inval) begin
            pv_q <= 1'b0;
        end else if (upd_valid && !upd_stale) begin
            pv_q    <= 1'b1;
            pvpn_q  <= upd_vpn;
            pasid_q <= upd_asid;
        end
    end

    // level 0 is the most significant index
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        assign lvl_eq[l] = pvpn_q[(LEVELS-1-l)*IDX_W +: IDX_W] == look_vpn[(LEVELS-1-l)*IDX_W +: IDX_W];
    end

    always_comb begin
        logic run;
        run       = pv_q && (pasid_q == look_asid);
        look_skip = '0;
        for (int l = 0; l < LEVELS - 1; l++) begin
            run = run && lvl_eq[l];
            if (run) look_skip = look_skip + SKIP_W'(1);
        end
    end

    // R8: an invalidation leaves nothing to skip in the following cycle
    assert_inval_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> (look_skip == '0));

    // R9: a stale completion must not move the recorded path
    assert_stale_keeps_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_stale) |=> ($stable(pvpn_q) && $stable(pasid_q)));
endmodule

// File: rtl/miss_merge_buf.sv
`timescale 1ns/1ps
module miss_merge_buf #(
    parameter int ENTRIES = 32,
    parameter int TAGS    = 8,
    parameter int LEVELS  = 4,
    parameter int IDX_W   = 9,
    parameter int ASID_W  = 8,
    parameter int PPN_W   = 24,
    parameter int NWALK   = 4,
    localparam int VPN_W  = LEVELS * IDX_W,
    localparam int EID_W  = $clog2(ENTRIES),
    localparam int TAG_W  = $clog2(TAGS),
    localparam int SKIP_W = $clog2(LEVELS),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [ASID_W-1:0] miss_asid,
    input  logic [TAG_W-1:0]  miss_tag,
    input  logic              inval,
    output logic              walk_req_valid,
    output logic [EID_W-1:0]  walk_req_id,
    output logic [VPN_W-1:0]  walk_req_vpn,
    output logic [ASID_W-1:0] walk_req_asid,
    output logic [SKIP_W-1:0] walk_req_skip,
    input  logic              walk_rsp_valid,
    input  logic [EID_W-1:0]  walk_rsp_id,
    input  logic [PPN_W-1:0]  walk_rsp_ppn,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [VPN_W-1:0]  rsp_vpn,
    output logic [ASID_W-1:0] rsp_asid,
    output logic [PPN_W-1:0]  rsp_ppn
);
    import mmb_pkg::*;

    ent_state_e st_q [ENTRIES];
    ent_state_e st_d [ENTRIES];
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
    logic [ENTRIES-1:0][TAGS-1:0]   mask_q;
    logic [ENTRIES-1:0]             stale_q;

    logic [ENTRIES-1:0] free_v, wait_v, done_v, mergeable_v;
    logic [CNT_W-1:0]   busy;
    logic               hit, any_free, any_wait, drain_any, tag_any;
    logic [EID_W-1:0]   hit_idx, free_idx, wait_idx, drain_idx;
    logic [TAG_W-1:0]   tag_idx;
    logic               accept, alloc, issue, last_tag, rsp_hit;
    logic [TAGS-1:0]    tag_bit, drain_left;

    always_comb begin
        busy = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            free_v[i]      = (st_q[i] == ENT_FREE);
            wait_v[i]      = (st_q[i] == ENT_WAIT);
            done_v[i]      = (st_q[i] == ENT_DONE);
            mergeable_v[i] = (st_q[i] == ENT_WAIT || st_q[i] == ENT_WALK) && !stale_q[i] && !inval;
            busy           = busy + CNT_W'(st_q[i] == ENT_WALK);
        end
    end

    mmb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
        .mergeable(mergeable_v), .ent_vpn(vpn_q), .ent_asid(asid_q),
        .look_vpn(miss_vpn), .look_asid(miss_asid), .hit(hit), .hit_idx(hit_idx)
    );
    mmb_pick #(.N(ENTRIES)) u_free  (.req(free_v), .any(any_free),  .idx(free_idx));
    mmb_pick #(.N(ENTRIES)) u_wait  (.req(wait_v), .any(any_wait),  .idx(wait_idx));
    mmb_pick #(.N(ENTRIES)) u_drain (.req(done_v), .any(drain_any), .idx(drain_idx));
    mmb_pick #(.N(TAGS))    u_tag   (.req(mask_q[drain_idx]), .any(tag_any), .idx(tag_idx));

    assign miss_ready = hit || any_free;
    assign accept     = miss_valid && miss_ready;
    assign alloc      = accept && !hit;
    assign issue      = any_wait && (busy < CNT_W'(NWALK));
    assign tag_bit    = TAGS'(1) << miss_tag;
    assign drain_left = mask_q[drain_idx] & ~(TAGS'(1) << tag_idx);
    assign last_tag   = tag_any && (drain_left == '0);
    assign rsp_hit    = walk_rsp_valid && (st_q[walk_rsp_id] == ENT_WALK);

    mmb_path #(.LEVELS(LEVELS), .IDX_W(IDX_W), .ASID_W(ASID_W)) u_path (
        .clk(clk), .rst_n(rst_n), .inval(inval),
        .upd_valid(rsp_hit), .upd_stale(stale_q[walk_rsp_id] || inval),
        .upd_vpn(vpn_q[walk_rsp_id]), .upd_asid(asid_q[walk_rsp_id]),
        .look_vpn(vpn_q[wait_idx]), .look_asid(asid_q[wait_idx]), .look_skip(walk_req_skip)
    );

    // next state for every entry
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            st_d[i] = st_q[i];
            unique case (st_q[i])
                ENT_FREE: if (alloc && free_idx == EID_W'(i)) st_d[i] = ENT_WAIT;
                ENT_WAIT: if (issue && wait_idx == EID_W'(i)) st_d[i] = ENT_WALK;
                ENT_WALK: if (walk_rsp_valid && walk_rsp_id == EID_W'(i)) st_d[i] = ENT_DONE;
                ENT_DONE: if (drain_idx == EID_W'(i) && last_tag) st_d[i] = ENT_FREE;
            endcase
        end
    end

    // state register and entry payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) st_q[i] <= ENT_FREE;
            vpn_q   <= '0;
            asid_q  <= '0;
            ppn_q   <= '0;
            mask_q  <= '0;
            stale_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q[i] <= st_d[i];
                if (inval && (st_q[i] == ENT_WAIT || st_q[i] == ENT_WALK)) stale_q[i] <= 1'b1;
            end
            if (alloc) begin
                vpn_q[free_idx]   <= miss_vpn;
                asid_q[free_idx]  <= miss_asid;
                mask_q[free_idx]  <= tag_bit;
                stale_q[free_idx] <= 1'b0;
            end
            if (accept && hit) mask_q[hit_idx] <= mask_q[hit_idx] | tag_bit;
            if (rsp_hit) ppn_q[walk_rsp_id] <= walk_rsp_ppn;
            if (drain_any) mask_q[drain_idx] <= drain_left;
        end
    end

    // outputs
    always_comb begin
        walk_req_valid = issue;
        walk_req_id    = wait_idx;
        walk_req_vpn   = vpn_q[wait_idx];
        walk_req_asid  = asid_q[wait_idx];
        rsp_valid      = drain_any;
        rsp_tag        = tag_idx;
        rsp_vpn        = vpn_q[drain_idx];
        rsp_asid       = asid_q[drain_idx];
        rsp_ppn        = ppn_q[drain_idx];
    end

    // checker support: a fresh walk to the same page already in flight
    logic dup_walk;
    always_comb begin
        dup_walk = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (st_q[i] == ENT_WALK && !stale_q[i] && vpn_q[i] == vpn_q[wait_idx]
                && asid_q[i] == asid_q[wait_idx]) dup_walk = 1'b1;
        end
    end

    assert_walk_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy <= CNT_W'(NWALK));

    assert_no_dup_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !dup_walk);

    assert_tag_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rsp_valid) && drain_idx == $past(drain_idx)) |-> (rsp_tag > $past(rsp_tag)));

    assert_full_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !miss_ready) |-> (free_v == '0));
endmodule

// File: tb/miss_merge_buf_bench.sv
`timescale 1ns/1ps
module miss_merge_buf_bench;
    localparam int VPN_W = 36;
    localparam int AW    = 8;
    localparam int PW    = 24;
    localparam int MAXR  = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 1'b0, inval = 1'b0, walk_rsp_valid = 1'b0;
    logic [VPN_W-1:0] miss_vpn = '0;
    logic [AW-1:0] miss_asid = '0;
    logic [2:0] miss_tag = '0;
    logic [4:0] walk_rsp_id = '0;
    logic [PW-1:0] walk_rsp_ppn = '0;
    logic miss_ready, walk_req_valid, rsp_valid;
    logic [4:0] walk_req_id;
    logic [VPN_W-1:0] walk_req_vpn, rsp_vpn;
    logic [AW-1:0] walk_req_asid, rsp_asid;
    logic [1:0] walk_req_skip;
    logic [2:0] rsp_tag;
    logic [PW-1:0] rsp_ppn;

    always #4 clk = ~clk;

    miss_merge_buf u_miss_merge_buf (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_vpn(miss_vpn), .miss_asid(miss_asid), .miss_tag(miss_tag), .inval(inval),
        .walk_req_valid(walk_req_valid), .walk_req_id(walk_req_id), .walk_req_vpn(walk_req_vpn),
        .walk_req_asid(walk_req_asid), .walk_req_skip(walk_req_skip),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_id(walk_rsp_id), .walk_rsp_ppn(walk_rsp_ppn),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_vpn(rsp_vpn), .rsp_asid(rsp_asid),
        .rsp_ppn(rsp_ppn)
    );

    int nchk = 0, nerr = 0, cyc = 0, wn = 0, rn = 0;
    bit finished = 0;
    logic [4:0]       wq_id   [MAXR];
    logic [VPN_W-1:0] wq_vpn  [MAXR];
    logic [AW-1:0]    wq_asid [MAXR];
    logic [1:0]       wq_skip [MAXR];
    logic [2:0]       rq_tag  [MAXR];
    logic [VPN_W-1:0] rq_vpn  [MAXR];
    logic [AW-1:0]    rq_asid [MAXR];
    logic [PW-1:0]    rq_ppn  [MAXR];
    int               rq_cyc  [MAXR];

    // path model
    bit mp_valid = 0;
    logic [VPN_W-1:0] mp_vpn = '0;
    logic [AW-1:0] mp_asid = '0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && walk_req_valid && wn < MAXR) begin
            wq_id[wn] = walk_req_id; wq_vpn[wn] = walk_req_vpn;
            wq_asid[wn] = walk_req_asid; wq_skip[wn] = walk_req_skip;
            wn = wn + 1;
        end
        if (rst_n && rsp_valid && rn < MAXR) begin
            rq_tag[rn] = rsp_tag; rq_vpn[rn] = rsp_vpn; rq_asid[rn] = rsp_asid;
            rq_ppn[rn] = rsp_ppn; rq_cyc[rn] = cyc;
            rn = rn + 1;
        end
    end

    function automatic logic [PW-1:0] ppn_of(logic [VPN_W-1:0] v, logic [AW-1:0] a);
        return v[PW-1:0] ^ {a, 16'h0} ^ 24'h00A5A5;
    endfunction

    function automatic logic [VPN_W-1:0] mk(int i3, int i2, int i1, int i0);
        return {9'(i3), 9'(i2), 9'(i1), 9'(i0)};
    endfunction

    function automatic int exp_skip(logic [VPN_W-1:0] v, logic [AW-1:0] a);
        int k = 0;
        if (!mp_valid || mp_asid != a) return 0;
        for (int l = 0; l < 3; l++) begin
            if (mp_vpn[(3-l)*9 +: 9] != v[(3-l)*9 +: 9]) return k;
            k++;
        end
        return k;
    endfunction

    task automatic chk(string rq, string what, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [VPN_W-1:0] v, logic [AW-1:0] a, int t);
        int guard = 0;
        @(negedge clk);
        miss_valid = 1; miss_vpn = v; miss_asid = a; miss_tag = 3'(t);
        #1;
        while (!miss_ready && guard < 400) begin @(negedge clk); #1; guard++; end
        @(posedge clk); #1;
        miss_valid = 0;
    endtask

    task automatic probe(logic [VPN_W-1:0] v, logic [AW-1:0] a, output bit rdy);
        @(negedge clk);
        miss_valid = 1; miss_vpn = v; miss_asid = a; miss_tag = 3'd0;
        #1; rdy = miss_ready;
        miss_valid = 0;
    endtask

    task automatic wait_wn(int n);
        int t = 0;
        while (wn < n && t < 300) begin @(negedge clk); t++; end
    endtask

    task automatic respond(int r, bit stale);
        @(negedge clk);
        walk_rsp_valid = 1; walk_rsp_id = wq_id[r];
        walk_rsp_ppn = ppn_of(wq_vpn[r], wq_asid[r]);
        @(posedge clk); #1;
        walk_rsp_valid = 0;
        if (!stale) begin mp_valid = 1; mp_vpn = wq_vpn[r]; mp_asid = wq_asid[r]; end
    endtask

    task automatic do_inval();
        @(negedge clk); inval = 1;
        @(posedge clk); #1; inval = 0;
        mp_valid = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=hung expected=complete");
            summary();
            $finish;
        end
    end

    initial begin
        int b, rb, es;
        bit rdy;
        logic [VPN_W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R1", "miss_ready", miss_ready, 1);
        chk("R1", "walk_req_valid", walk_req_valid, 0);
        chk("R1", "rsp_valid", rsp_valid, 0);

        // R2 / R6: merge five tags, answered in ascending order
        b = wn; rb = rn;
        v = mk(1, 2, 3, 4);
        send(v, 8'd1, 5); send(v, 8'd1, 2); send(v, 8'd1, 7); send(v, 8'd1, 0); send(v, 8'd1, 3);
        idle(4);
        chk("R2", "walks for merged page", wn - b, 1);
        chk("R7", "skip with empty path", wq_skip[b], 0);
        respond(b, 0);
        idle(10);
        chk("R6", "response count", rn - rb, 5);
        begin
            int exp_t[5] = '{0, 2, 3, 5, 7};
            for (int i = 0; i < 5; i++) begin
                chk("R6", "tag order", rq_tag[rb+i], exp_t[i]);
                chk("R6", "ppn", rq_ppn[rb+i], ppn_of(v, 8'd1));
                chk("R6", "vpn", rq_vpn[rb+i], v);
                if (i > 0) chk("R6", "consecutive cycles", rq_cyc[rb+i] - rq_cyc[rb+i-1], 1);
            end
        end

        // R2 / R6: all eight tags in reverse order
        b = wn; rb = rn;
        v = mk(7, 7, 7, 7);
        for (int t = 7; t >= 0; t--) send(v, 8'd1, t);
        idle(4);
        chk("R2", "walks for eight-tag page", wn - b, 1);
        respond(b, 0);
        idle(14);
        chk("R6", "eight responses", rn - rb, 8);
        for (int i = 0; i < 8; i++) chk("R6", "tag sweep", rq_tag[rb+i], i);

        // R3: same page under two address spaces
        b = wn; rb = rn;
        v = mk(9, 9, 9, 9);
        send(v, 8'd1, 0); send(v, 8'd2, 1);
        idle(4);
        chk("R3", "separate walks", wn - b, 2);
        respond(b, 0); respond(b + 1, 0);
        idle(6);
        chk("R3", "two responses", rn - rb, 2);
        for (int i = 0; i < 2; i++) begin
            chk("R3", "asid follows tag", rq_asid[rb+i], (rq_tag[rb+i] == 0) ? 1 : 2);
            chk("R3", "ppn per space", rq_ppn[rb+i], ppn_of(v, rq_asid[rb+i]));
        end

        // R7: skip sweep against the path model
        for (int k = 0; k <= 4; k++) begin
            v = mp_vpn;
            if (k < 4) v[(3-k)*9 +: 9] = v[(3-k)*9 +: 9] ^ 9'h1;
            for (int l = k + 1; l < 4; l++) v[(3-l)*9 +: 9] = 9'(k * 11 + l);
            es = exp_skip(v, mp_asid);
            chk("R7", "model skip", es, (k > 3) ? 3 : k);
            b = wn;
            send(v, mp_asid, 0);
            wait_wn(b + 1);
            chk("R7", "skip sweep", wq_skip[b], es);
            respond(b, 0);
            idle(4);
        end
        v = mp_vpn; b = wn;
        send(v, mp_asid ^ 8'h40, 0);
        wait_wn(b + 1);
        chk("R7", "skip other asid", wq_skip[b], 0);
        respond(b, 0);
        idle(4);

        // R8: invalidation empties the path register
        v = mp_vpn; b = wn;
        do_inval();
        send(v, mp_asid, 0);
        wait_wn(b + 1);
        chk("R8", "skip after inval", wq_skip[b], 0);
        respond(b, 0);
        idle(4);

        // R5: walker limit and lowest-index issue
        b = wn; rb = rn;
        for (int i = 0; i < 6; i++) send(mk(20 + i, 1, 1, i), 8'd3, 0);
        idle(6);
        chk("R5", "walks capped", wn - b, 4);
        respond(b, 0);
        idle(5);
        chk("R5", "fifth walk after free", wn - b, 5);
        chk("R5", "lowest waiting index", wq_id[b+4], 4);
        for (int j = 1; j < 6; j++) begin wait_wn(b + j + 1); respond(b + j, 0); end
        idle(8);
        chk("R5", "all answered", rn - rb, 6);

        // R4: fill all entries
        b = wn; rb = rn;
        for (int i = 0; i < 32; i++) send(mk(100 + i, 3, 3, 3), 8'd5, 0);
        probe(mk(200, 0, 0, 0), 8'd5, rdy);
        chk("R4", "ready when full", rdy, 0);
        probe(mk(110, 3, 3, 3), 8'd5, rdy);
        chk("R4", "ready for match when full", rdy, 1);
        send(mk(110, 3, 3, 3), 8'd5, 1);
        for (int j = 0; j < 32; j++) begin wait_wn(b + j + 1); respond(b + j, 0); end
        idle(12);
        chk("R4", "walks when full", wn - b, 32);
        chk("R4", "responses incl merged", rn - rb, 33);

        // R9: stale walk beside a fresh walk
        b = wn; rb = rn;
        v = mk(40, 41, 42, 43);
        send(v, 8'd4, 1);
        wait_wn(b + 1);
        do_inval();
        send(v, 8'd4, 2);
        idle(4);
        chk("R9", "no merge into stale", wn - b, 2);
        respond(b, 1);
        idle(4);
        chk("R9", "stale answered", rn - rb, 1);
        chk("R9", "stale tag", rq_tag[rb], 1);
        chk("R9", "stale ppn", rq_ppn[rb], ppn_of(v, 8'd4));
        send(mk(40, 41, 42, 99), 8'd4, 3);
        wait_wn(b + 3);
        chk("R9", "path untouched by stale", wq_skip[b+2], 0);
        respond(b + 1, 0);
        respond(b + 2, 0);
        idle(6);
        chk("R9", "all answered", rn - rb, 3);

        finished = 1;
        summary();
        $finish;
    end
endmodule